// File: doc/BRIEF.md
# Branch Resolution and Fetch Redirect Unit

This unit sits at the execute stage of a five-stage, word-addressed 32-bit pipeline. It also owns the fetch program counter. Fetch always assumes that control flow falls through. The instruction in execute is checked for a change of flow: a conditional skip, an unconditional jump or a jump-and-link. When the guess turns out wrong, the unit redirects fetch to the correct address. On that redirect it cancels the two younger instructions by steering an all-zero no-op word into the pipeline buffers. It never clears registers asynchronously.

A skip compares two register operands. When the comparison holds, execution resumes two words past the skip, so the one instruction that follows it is passed over. The jump adds a signed 20-bit offset to the incremented PC. Jump-and-link takes its target from a register and returns the incremented PC as a link value, which the write-back path stores. A halt opcode seen in decode freezes the fetch PC until the next reset.

Top module: `branch_flush_unit`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, fetch_pc_o is 0 and halted_o is 0.
- R2: With no stall, no redirect and no halt, fetch_pc_o advances by 1 on each clock edge and wraps modulo 2^16.
- R3: When stall_i is high and there is no redirect, fetch_pc_o holds its value, ifid_hold_o is 1 and idex_bubble_o is 1.
- R4: Opcode 4'b1000 with mode 0 redirects when the two operands are equal. The new PC is ex_pc_inc_i + 1, truncated to 16 bits. Unequal operands give no redirect.
- R5: Opcode 4'b1000 with mode 1 redirects when ex_op_a_i is less than ex_op_b_i as signed 32-bit values. Any other mode value never redirects.
- R6: Opcode 4'b0101 always redirects. The new PC is the low 16 bits of ex_pc_inc_i plus the sign-extended ex_offset_i.
- R7: Opcode 4'b0110 always redirects to ex_op_a_i[15:0]. It sets link_we_o to 1 and drives link_o with ex_pc_inc_i zero-extended to 32 bits. Every other opcode gives link_we_o = 0.
- R8: During a redirect, if_instr_o is the no-op word 32'h0 (ADD zero,zero,zero) and idex_bubble_o is 1. Without a redirect or stall, if_instr_o equals if_instr_i and idex_bubble_o is 0.
- R9: When a redirect and a stall arrive in the same cycle, the redirect wins: ifid_hold_o is 0 and the PC loads the target.
- R10: dec_opcode_i = 4'b0111 with no redirect freezes fetch_pc_o from that edge onward. halted_o rises on the next edge and stays high until reset, and later redirects no longer move the PC. A redirect in the same cycle as the halt cancels the halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Hazard stall request from decode |
| dec_opcode_i | input | 4 | Opcode of the instruction in decode (halt detection) |
| ex_opcode_i | input | 4 | Opcode of the instruction in execute |
| ex_mode_i | input | 4 | Skip comparison mode |
| ex_op_a_i | input | 32 | First source operand (SR1 / jump target register) |
| ex_op_b_i | input | 32 | Second source operand (SR2) |
| ex_pc_inc_i | input | 16 | Incremented PC of the execute instruction |
| ex_offset_i | input | 20 | PC-relative offset field |
| if_instr_i | input | 32 | Word fetched from instruction memory |
| fetch_pc_o | output | 16 | Instruction memory address |
| redirect_o | output | 1 | Fetch redirect / flush request |
| link_we_o | output | 1 | Link register write request |
| link_o | output | 32 | Return address for jump-and-link |
| if_instr_o | output | 32 | Word to load into the fetch/decode buffer |
| ifid_hold_o | output | 1 | Hold enable for PC-side buffer |
| idex_bubble_o | output | 1 | Load no-op into decode/execute buffer |
| halted_o | output | 1 | Machine halted |

## Verification
The bench targets a skip with mode 1 where one operand is negative. An unsigned compare would take the wrong direction there. It also drives jumps whose sum wraps past 16 bits, where a design that forgot truncation or sign extension would fetch from the wrong address. It applies a stall together with a redirect: a stall-first design would keep a wrong-path instruction and drop the target. It sends a halt that an older redirect cancels, and a halt followed by later redirects, where a wrong design would either freeze on a squashed halt or keep moving after a real one.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam logic [3:0] OP_GOTO = 4'b0101;
  localparam logic [3:0] OP_JALR = 4'b0110;
  localparam logic [3:0] OP_HALT = 4'b0111;
  localparam logic [3:0] OP_SKIP = 4'b1000;

  localparam logic [3:0] SKIP_EQ = 4'd0;
  localparam logic [3:0] SKIP_LT = 4'd1;
endpackage

// File: rtl/bfu_resolve.sv
module bfu_resolve #(
  parameter int XLEN   = 32,
  parameter int PC_W   = 16,
  parameter int OFF_W  = 20,
  parameter int MODE_W = 4
) (
  input  logic [3:0]        opcode_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [XLEN-1:0]   op_a_i,
  input  logic [XLEN-1:0]   op_b_i,
  input  logic [PC_W-1:0]   pc_inc_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic              redirect_o,
  output logic [PC_W-1:0]   target_o,
  output logic              link_we_o,
  output logic [XLEN-1:0]   link_o
);
  import bfu_pkg::*;

  logic [PC_W-1:0] off_pc;
  logic            skip_hit;

  // offset brought to PC width; truncation makes sign extension moot when wider
  generate
    if (OFF_W >= PC_W) begin : g_off_trunc
      logic off_unused;
      if (OFF_W > PC_W) begin : g_drop
        assign off_unused = ^offset_i[OFF_W-1:PC_W];
      end else begin : g_none
        assign off_unused = 1'b0;
      end
      assign off_pc = offset_i[PC_W-1:0];
    end else begin : g_off_sext
      assign off_pc = {{(PC_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
    end
  endgenerate

  always_comb begin
    unique case (mode_i)
      MODE_W'(SKIP_EQ): skip_hit = (op_a_i == op_b_i);
      MODE_W'(SKIP_LT): skip_hit = ($signed(op_a_i) < $signed(op_b_i));
      default:          skip_hit = 1'b0;
    endcase
  end

  always_comb begin
    redirect_o = 1'b0;
    target_o   = pc_inc_i;
    link_we_o  = 1'b0;
    link_o     = {{(XLEN-PC_W){1'b0}}, pc_inc_i};
    unique case (opcode_i)
      OP_SKIP: begin
        redirect_o = skip_hit;
        target_o   = pc_inc_i + PC_W'(1);
      end
      OP_GOTO: begin
        redirect_o = 1'b1;
        target_o   = pc_inc_i + off_pc;
      end
      OP_JALR: begin
        redirect_o = 1'b1;
        target_o   = op_a_i[PC_W-1:0];
        link_we_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bfu_pc_reg.sv
module bfu_pc_reg #(
  parameter int PC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            halt_dec_i,
  input  logic            redirect_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o,
  output logic            halted_o
);
  logic [PC_W-1:0] pc_q, pc_d;
  logic            halted_q, halt_now;

  // an older redirect squashes the halt sitting in decode
  assign halt_now = halt_dec_i & ~redirect_i;

  always_comb begin
    if (halted_q)                   pc_d = pc_q;
    else if (redirect_i)            pc_d = target_i;
    else if (halt_now || stall_i)   pc_d = pc_q;
    else                            pc_d = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      pc_q     <= pc_d;
      halted_q <= halted_q | halt_now;
    end
  end

  assign pc_o     = pc_q;
  assign halted_o = halted_q;
endmodule

// File: rtl/bfu_squash.sv
module bfu_squash #(
  parameter int IW = 32
) (
  input  logic          redirect_i,
  input  logic          stall_i,
  input  logic [IW-1:0] instr_i,
  output logic [IW-1:0] instr_o,
  output logic          ifid_hold_o,
  output logic          idex_bubble_o
);
  localparam logic [IW-1:0] NOP_WORD = '0;

  assign instr_o       = redirect_i ? NOP_WORD : instr_i;
  assign ifid_hold_o   = stall_i & ~redirect_i;   // flush beats stall
  assign idex_bubble_o = redirect_i | stall_i;
endmodule

// File: rtl/branch_flush_unit.sv
module branch_flush_unit #(
  parameter int XLEN   = 32,
  parameter int PC_W   = 16,
  parameter int OFF_W  = 20,
  parameter int MODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic [3:0]        dec_opcode_i,
  input  logic [3:0]        ex_opcode_i,
  input  logic [MODE_W-1:0] ex_mode_i,
  input  logic [XLEN-1:0]   ex_op_a_i,
  input  logic [XLEN-1:0]   ex_op_b_i,
  input  logic [PC_W-1:0]   ex_pc_inc_i,
  input  logic [OFF_W-1:0]  ex_offset_i,
  input  logic [XLEN-1:0]   if_instr_i,
  output logic [PC_W-1:0]   fetch_pc_o,
  output logic              redirect_o,
  output logic              link_we_o,
  output logic [XLEN-1:0]   link_o,
  output logic [XLEN-1:0]   if_instr_o,
  output logic              ifid_hold_o,
  output logic              idex_bubble_o,
  output logic              halted_o
);
  import bfu_pkg::*;

  logic [PC_W-1:0] target;

  bfu_resolve #(.XLEN(XLEN), .PC_W(PC_W), .OFF_W(OFF_W), .MODE_W(MODE_W)) u_resolve (
    .opcode_i   (ex_opcode_i),
    .mode_i     (ex_mode_i),
    .op_a_i     (ex_op_a_i),
    .op_b_i     (ex_op_b_i),
    .pc_inc_i   (ex_pc_inc_i),
    .offset_i   (ex_offset_i),
    .redirect_o (redirect_o),
    .target_o   (target),
    .link_we_o  (link_we_o),
    .link_o     (link_o)
  );

  bfu_pc_reg #(.PC_W(PC_W)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stall_i    (stall_i),
    .halt_dec_i (dec_opcode_i == OP_HALT),
    .redirect_i (redirect_o),
    .target_i   (target),
    .pc_o       (fetch_pc_o),
    .halted_o   (halted_o)
  );

  bfu_squash #(.IW(XLEN)) u_squash (
    .redirect_i    (redirect_o),
    .stall_i       (stall_i),
    .instr_i       (if_instr_i),
    .instr_o       (if_instr_o),
    .ifid_hold_o   (ifid_hold_o),
    .idex_bubble_o (idex_bubble_o)
  );
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
  parameter int XLEN   = 32,
  parameter int PC_W   = 16,
  parameter int MODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_i,
  input logic [3:0]        dec_opcode_i,
  input logic [3:0]        ex_opcode_i,
  input logic [MODE_W-1:0] ex_mode_i,
  input logic [XLEN-1:0]   ex_op_a_i,
  input logic [XLEN-1:0]   ex_op_b_i,
  input logic [PC_W-1:0]   ex_pc_inc_i,
  input logic [PC_W-1:0]   fetch_pc_o,
  input logic              redirect_o,
  input logic              link_we_o,
  input logic [XLEN-1:0]   link_o,
  input logic [XLEN-1:0]   if_instr_o,
  input logic              ifid_hold_o,
  input logic              idex_bubble_o,
  input logic              halted_o
);
  AST_SEQ_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && !redirect_o && !stall_i && dec_opcode_i != 4'b0111)
      |=> fetch_pc_o == PC_W'($past(fetch_pc_o) + 1)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !redirect_o) |=> $stable(fetch_pc_o)); // R3

  AST_SKIP_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && ex_opcode_i == 4'b1000 && ex_mode_i == '0 && ex_op_a_i == ex_op_b_i)
      |=> fetch_pc_o == PC_W'($past(ex_pc_inc_i) + 1)); // R4

  AST_JALR_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_opcode_i == 4'b0110) |-> (link_we_o && redirect_o
      && link_o == {{(XLEN-PC_W){1'b0}}, ex_pc_inc_i})); // R7

  AST_SQUASH_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (if_instr_o == '0 && idex_bubble_o)); // R8

  AST_FLUSH_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> !ifid_hold_o); // R9

  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> ($stable(fetch_pc_o) && halted_o)); // R10
endmodule

bind branch_flush_unit bfu_checker #(.XLEN(XLEN), .PC_W(PC_W), .MODE_W(MODE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .stall_i       (stall_i),
  .dec_opcode_i  (dec_opcode_i),
  .ex_opcode_i   (ex_opcode_i),
  .ex_mode_i     (ex_mode_i),
  .ex_op_a_i     (ex_op_a_i),
  .ex_op_b_i     (ex_op_b_i),
  .ex_pc_inc_i   (ex_pc_inc_i),
  .fetch_pc_o    (fetch_pc_o),
  .redirect_o    (redirect_o),
  .link_we_o     (link_we_o),
  .link_o        (link_o),
  .if_instr_o    (if_instr_o),
  .ifid_hold_o   (ifid_hold_o),
  .idex_bubble_o (idex_bubble_o),
  .halted_o      (halted_o)
);

// File: tb/branch_flush_unit_tb.sv
module branch_flush_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stall_i = 1'b0;
  logic [3:0]  dec_opcode_i = '0;
  logic [3:0]  ex_opcode_i = '0;
  logic [3:0]  ex_mode_i = '0;
  logic [31:0] ex_op_a_i = '0;
  logic [31:0] ex_op_b_i = '0;
  logic [15:0] ex_pc_inc_i = '0;
  logic [19:0] ex_offset_i = '0;
  logic [31:0] if_instr_i = '0;
  logic [15:0] fetch_pc_o;
  logic        redirect_o, link_we_o, ifid_hold_o, idex_bubble_o, halted_o;
  logic [31:0] link_o, if_instr_o;

  int n_tests = 0;
  int n_fail  = 0;
  int m_pc    = 0;
  bit m_halt  = 1'b0;
  bit done    = 1'b0;

  always #5 clk_i = ~clk_i;

  branch_flush_unit u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_redir(input logic [3:0] op, input logic [3:0] md,
                                   input logic [31:0] a, input logic [31:0] b);
    if (op == 4'b1000) begin
      if (md == 0) return a == b;
      if (md == 1) return $signed(a) < $signed(b);
      return 1'b0;
    end
    return (op == 4'b0101) || (op == 4'b0110);
  endfunction

  function automatic int exp_target(input logic [3:0] op, input logic [31:0] a,
                                    input logic [15:0] pci, input logic [19:0] off);
    int sx;
    sx = (off >= 20'h80000) ? int'(off) - 32'h100000 : int'(off);
    if (op == 4'b1000) return (int'(pci) + 1) & 16'hFFFF;
    if (op == 4'b0101) return (int'(pci) + sx) & 16'hFFFF;
    return int'(a[15:0]);
  endfunction

  // one cycle: drive, check combinational outputs, clock, check state
  task automatic step(input bit st, input logic [3:0] dop, input logic [3:0] eop,
                      input logic [3:0] md, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] pci, input logic [19:0] off, input string tag);
    bit r;
    int tgt;
    logic [31:0] ins;
    @(negedge clk_i);
    ins = $urandom | 32'h1;
    stall_i = st; dec_opcode_i = dop; ex_opcode_i = eop; ex_mode_i = md;
    ex_op_a_i = a; ex_op_b_i = b; ex_pc_inc_i = pci; ex_offset_i = off; if_instr_i = ins;
    #1;
    r   = exp_redir(eop, md, a, b);
    tgt = exp_target(eop, a, pci, off);
    chk(redirect_o == r, {tag, " redirect"}, redirect_o, r);
    chk(if_instr_o == (r ? 32'h0 : ins), {tag, " R8 instr mux"}, if_instr_o, r ? 0 : ins);
    chk(idex_bubble_o == (r | st), {tag, " R8 bubble"}, idex_bubble_o, r | st);
    chk(ifid_hold_o == (st & ~r), {tag, " R9 hold"}, ifid_hold_o, st & ~r);
    chk(link_we_o == (eop == 4'b0110), {tag, " R7 link_we"}, link_we_o, eop == 4'b0110);
    if (eop == 4'b0110)
      chk(link_o == {16'h0, pci}, {tag, " R7 link"}, link_o, {16'h0, pci});
    if (!m_halt) begin
      if (r) m_pc = tgt;
      else if (!(dop == 4'b0111 || st)) m_pc = (m_pc + 1) & 16'hFFFF;
      if (dop == 4'b0111 && !r) m_halt = 1'b1;
    end
    @(posedge clk_i);
    #1;
    chk(fetch_pc_o == m_pc[15:0], {tag, " pc"}, fetch_pc_o, m_pc);
    chk(halted_o == m_halt, {tag, " R10 halted"}, halted_o, m_halt);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; stall_i = 0; dec_opcode_i = 0; ex_opcode_i = 0;
    #1;
    chk(fetch_pc_o == 0, "R1 pc in reset", fetch_pc_o, 0);
    chk(halted_o == 0, "R1 halted in reset", halted_o, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_pc = 0; m_halt = 0;
    @(posedge clk_i);
    #1;
    chk(fetch_pc_o == 1, "R1 first pc after reset", fetch_pc_o, 1);
    chk(halted_o == 0, "R1 halted after reset", halted_o, 0);
    m_pc = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2 sequential
    repeat (5) step(0, 0, 0, 0, 0, 0, 0, 0, "R2 seq");
    // R3 stall
    repeat (3) step(1, 0, 0, 0, 0, 0, 0, 0, "R3 stall");
    // R4 skip equal / not equal
    step(0, 0, 4'b1000, 0, 32'h55, 32'h55, 16'h0040, 0, "R4 skip eq taken");
    step(0, 0, 4'b1000, 0, 32'h55, 32'h56, 16'h0050, 0, "R4 skip eq not taken");
    step(0, 0, 4'b1000, 0, 7, 7, 16'hFFFF, 0, "R4 skip wrap");
    // R5 signed less-than, other modes
    step(0, 0, 4'b1000, 1, 32'hFFFF_FFFE, 32'h3, 16'h0100, 0, "R5 lt neg<pos");
    step(0, 0, 4'b1000, 1, 32'h3, 32'hFFFF_FFFE, 16'h0200, 0, "R5 lt pos<neg false");
    step(0, 0, 4'b1000, 1, 32'h9, 32'h9, 16'h0300, 0, "R5 lt equal false");
    step(0, 0, 4'b1000, 2, 32'h1, 32'h1, 16'h0400, 0, "R5 mode2 no skip");
    // R6 jumps
    step(0, 0, 4'b0101, 0, 0, 0, 16'h1000, 20'h00010, "R6 goto fwd");
    step(0, 0, 4'b0101, 0, 0, 0, 16'h0004, 20'hFFFF8, "R6 goto back wrap");
    step(0, 0, 4'b0101, 0, 0, 0, 16'hFFF0, 20'h7FFFF, "R6 goto large");
    // R7 jump-and-link
    step(0, 0, 4'b0110, 0, 32'hABCD_1234, 0, 16'h0777, 0, "R7 jalr");
    // R9 flush beats stall
    step(1, 0, 4'b0101, 0, 0, 0, 16'h2000, 20'h00020, "R9 flush+stall");
    step(1, 0, 4'b1000, 0, 4, 4, 16'h3000, 0, "R9 skip+stall");
    // R10 halt cancelled by older redirect, then real halt
    step(0, 4'b0111, 4'b0110, 0, 32'h0000_0500, 0, 16'h0010, 0, "R10 halt squashed");
    repeat (2) step(0, 0, 0, 0, 0, 0, 0, 0, "R2 seq after");
    step(0, 4'b0111, 0, 0, 0, 0, 0, 0, "R10 halt");
    step(0, 0, 4'b0101, 0, 0, 0, 16'h4000, 20'h00001, "R10 redirect after halt");
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, "R10 frozen");
    do_reset();
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [3:0] dop, eop;
      logic [31:0] a, b;
      int sel;
      dop = 4'($urandom % 16);
      if (dop == 4'b0111) dop = 0;
      sel = $urandom % 5;
      eop = (sel == 0) ? 4'b0101 : (sel == 1) ? 4'b0110 : (sel == 2) ? 4'b1000 : 4'b0001;
      a = $urandom; b = ($urandom % 3 == 0) ? a : $urandom;
      step(($urandom % 4) == 0, dop, eop, 4'($urandom % 3), a, b, 16'($urandom),
           20'($urandom), "R2 R4 R5 R6 mixed");
    end
    step(0, 4'b0111, 0, 0, 0, 0, 0, 0, "R10 final halt");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10 final frozen");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule